// File: doc/BRIEF.md
# Memory and I/O Window Address Decoder

This block decides, one bus address at a time, whether the address belongs to a logical device. It holds no configuration of its own. The descriptor fields come in as inputs from the register bank that software programs: four memory descriptors and eight I/O descriptors. The block returns one hit bit per descriptor and a single device select. Each result is registered, so it appears one clock after the address.

Each memory descriptor is built, by parameter, in one of two decode modes. In mask mode, the second field marks which of address bits [23:8] must equal the base. In limit mode, the second field is an exclusive upper bound, and the address must lie from the base up to that bound. Each I/O descriptor covers a fixed power-of-two window that starts at its base. The size of that window is a per-descriptor parameter. An I/O descriptor can also be narrowed to 10-bit decoding. A descriptor that is programmed to zero is switched off.

Top module: `res_window_decode`

## Requirements
- R1: While rst_n is low, mem_hit, io_hit and dev_sel are all 0.
- R2: Every output reflects the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.
- R3: A memory descriptor m is in mask mode when MODE_LIMIT[m] is 0. Its base is mem_base[16m+15:16m] and its mask is mem_top[16m+15:16m], both covering address bits [23:8]. The descriptor hits when every address bit whose mask bit is 1 equals the base bit. Bits with a mask bit of 0 are not compared, and address bits [7:0] are never compared.
- R4: A memory descriptor m is in limit mode when MODE_LIMIT[m] is 1. It hits when base <= addr[23:8] < top, compared unsigned. The top value is one past the last 256-byte unit of the range.
- R5: A memory descriptor whose base and top fields are both zero never hits, in either mode.
- R6: A memory descriptor hits only when mem_cyc is 1. An I/O descriptor hits only when io_cyc is 1.
- R7: An I/O descriptor i has base io_base[16i+15:16i] and window size 2^SPAN, where SPAN = IO_SPAN_LOG2[4i+3:4i]. It hits when base <= addr[15:0] < base + 2^SPAN.
- R8: An I/O descriptor whose base field is 0x0000 never hits.
- R9: When io_dec10 is 1, I/O address bits [15:10] are ignored. The window compare then uses only bits [9:0] of both the address and the base.
- R10: dev_sel is 1 exactly when at least one mem_hit or io_hit bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Bus address |
| mem_cyc | input | 1 | Current cycle is a memory cycle |
| io_cyc | input | 1 | Current cycle is an I/O cycle |
| io_dec10 | input | 1 | Restrict I/O decode to 10 address bits |
| mem_base | input | 64 | Four memory bases, address bits [23:8] each |
| mem_top | input | 64 | Four masks or exclusive upper limits, bits [23:8] each |
| io_base | input | 128 | Eight 16-bit I/O bases |
| mem_hit | output | 4 | Registered per-descriptor memory hit |
| io_hit | output | 8 | Registered per-descriptor I/O hit |
| dev_sel | output | 1 | Registered OR of all hits |

## Verification
The assertions run on every cycle. They check that:
- every memory or I/O hit was preceded by the matching cycle flag;
- no descriptor that was programmed to zero ever hits;
- a limit-mode hit always lies between its base and its top;
- dev_sel agrees with the hit vectors.

Other behaviour can only be shown by the bench's scenarios:
- that a hit is raised when it should be;
- the mask semantics, including that bits [7:0] are ignored;
- the exclusive boundary at the top of a limit-mode range;
- the exclusive boundary at the end of an I/O window;
- the effect of 10-bit narrowing.

The bench checks these with directed edge addresses and random vectors, and compares every output with a model computed in the bench.

// File: rtl/res_window_decode.sv
module res_window_decode #(
  parameter int NUM_MEM = 4,
  parameter int NUM_IO = 8,
  parameter int ADDR_W = 24,
  parameter int FIELD_W = 16,
  parameter int IO_W = 16,
  parameter int IO_NARROW_W = 10,
  parameter logic [NUM_MEM-1:0] MODE_LIMIT = 4'b1010,
  parameter logic [NUM_IO*4-1:0] IO_SPAN_LOG2 = 32'h4321_4321
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       mem_cyc,
  input  logic                       io_cyc,
  input  logic                       io_dec10,
  input  logic [NUM_MEM*FIELD_W-1:0] mem_base,
  input  logic [NUM_MEM*FIELD_W-1:0] mem_top,
  input  logic [NUM_IO*IO_W-1:0]     io_base,
  output logic [NUM_MEM-1:0]         mem_hit,
  output logic [NUM_IO-1:0]          io_hit,
  output logic                       dev_sel
);
  localparam int LOW_W = ADDR_W - FIELD_W;
  localparam logic [IO_W-1:0] NARROW_KEEP = {IO_W{1'b1}} >> (IO_W - IO_NARROW_W);

  logic [FIELD_W-1:0] a_hi;
  logic [IO_W-1:0]    io_keep;
  logic [IO_W:0]      a_io;
  logic [NUM_MEM-1:0] mem_nx;
  logic [NUM_IO-1:0]  io_nx;

  assign a_hi    = bus_addr[ADDR_W-1:LOW_W];
  assign io_keep = io_dec10 ? NARROW_KEEP : {IO_W{1'b1}};
  assign a_io    = {1'b0, bus_addr[IO_W-1:0] & io_keep};

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    logic [FIELD_W-1:0] b, t;
    logic on, match;
    assign b  = mem_base[m*FIELD_W +: FIELD_W];
    assign t  = mem_top[m*FIELD_W +: FIELD_W];
    assign on = |{b, t};
    if (MODE_LIMIT[m]) begin : g_limit
      assign match = (a_hi >= b) && (a_hi < t);
    end else begin : g_mask
      assign match = ((a_hi ^ b) & t) == '0;
    end
    assign mem_nx[m] = mem_cyc & on & match;
  end

  for (genvar i = 0; i < NUM_IO; i++) begin : g_io
    localparam int SPAN = int'(IO_SPAN_LOG2[i*4 +: 4]);
    logic [IO_W-1:0] b;
    logic [IO_W:0]   lo, hi;
    assign b  = io_base[i*IO_W +: IO_W];
    assign lo = {1'b0, b & io_keep};
    assign hi = lo + ((IO_W+1)'(1) << SPAN);
    assign io_nx[i] = io_cyc & (|b) & (a_io >= lo) & (a_io < hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_hit <= '0;
      io_hit  <= '0;
      dev_sel <= 1'b0;
    end else begin
      mem_hit <= mem_nx;
      io_hit  <= io_nx;
      dev_sel <= |{mem_nx, io_nx};
    end
  end
endmodule

// File: rtl/res_window_decode_chk.sv
module res_window_decode_chk #(
  parameter int NUM_MEM = 4,
  parameter int NUM_IO = 8,
  parameter int ADDR_W = 24,
  parameter int FIELD_W = 16,
  parameter int IO_W = 16,
  parameter logic [NUM_MEM-1:0] MODE_LIMIT = 4'b1010
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       mem_cyc,
  input logic                       io_cyc,
  input logic [NUM_MEM*FIELD_W-1:0] mem_base,
  input logic [NUM_MEM*FIELD_W-1:0] mem_top,
  input logic [NUM_IO*IO_W-1:0]     io_base,
  input logic [NUM_MEM-1:0]         mem_hit,
  input logic [NUM_IO-1:0]          io_hit,
  input logic                       dev_sel
);
  localparam int LOW_W = ADDR_W - FIELD_W;

  a_r6_mem_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_hit) |-> $past(mem_cyc));

  a_r6_io_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|io_hit) |-> $past(io_cyc));

  a_r10_sel_matches_hits: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel == ((|mem_hit) || (|io_hit)));

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mchk
    a_r5_zero_mem_silent: assert property (@(posedge clk) disable iff (!rst_n)
      mem_hit[m] |-> ($past({mem_base[m*FIELD_W +: FIELD_W], mem_top[m*FIELD_W +: FIELD_W]}) != '0));
    if (MODE_LIMIT[m]) begin : g_lim
      a_r4_limit_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit[m] |->
          (($past(bus_addr[ADDR_W-1:LOW_W]) >= $past(mem_base[m*FIELD_W +: FIELD_W])) &&
           ($past(bus_addr[ADDR_W-1:LOW_W]) <  $past(mem_top[m*FIELD_W +: FIELD_W]))));
    end
  end

  for (genvar i = 0; i < NUM_IO; i++) begin : g_ichk
    a_r8_zero_io_silent: assert property (@(posedge clk) disable iff (!rst_n)
      io_hit[i] |-> ($past(io_base[i*IO_W +: IO_W]) != '0));
  end
endmodule

bind res_window_decode res_window_decode_chk #(
  .NUM_MEM(NUM_MEM), .NUM_IO(NUM_IO), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
  .IO_W(IO_W), .MODE_LIMIT(MODE_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .mem_cyc(mem_cyc), .io_cyc(io_cyc),
  .mem_base(mem_base), .mem_top(mem_top), .io_base(io_base),
  .mem_hit(mem_hit), .io_hit(io_hit), .dev_sel(dev_sel)
);

// File: tb/test_res_window_decode.sv
module test_res_window_decode;
  localparam logic [3:0]  MODE = 4'b1010;
  localparam logic [31:0] SPANS = 32'h4321_4321;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic mem_cyc = 1'b0, io_cyc = 1'b0, io_dec10 = 1'b0;
  logic [63:0] mem_base = '0, mem_top = '0;
  logic [127:0] io_base = '0;
  logic [3:0] mem_hit;
  logic [7:0] io_hit;
  logic dev_sel;
  int vectors = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  res_window_decode i_res_window_decode (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .mem_cyc(mem_cyc), .io_cyc(io_cyc),
    .io_dec10(io_dec10), .mem_base(mem_base), .mem_top(mem_top), .io_base(io_base),
    .mem_hit(mem_hit), .io_hit(io_hit), .dev_sel(dev_sel)
  );

  function automatic logic [3:0] exp_mem();
    logic [3:0] r = '0;
    for (int m = 0; m < 4; m++) begin
      logic [15:0] b = mem_base[m*16 +: 16];
      logic [15:0] t = mem_top[m*16 +: 16];
      logic [15:0] ah = bus_addr[23:8];
      bit ok = 1'b1;
      if (!mem_cyc || (b == 0 && t == 0)) continue;
      if (MODE[m]) ok = (ah >= b) && (ah < t);
      else for (int k = 0; k < 16; k++) if (t[k] && (ah[k] != b[k])) ok = 1'b0;
      r[m] = ok;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_io();
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      int b = int'(io_base[i*16 +: 16]);
      int a = int'(bus_addr[15:0]);
      int sz = 1 << int'(SPANS[i*4 +: 4]);
      if (!io_cyc || b == 0) continue;
      if (io_dec10) begin a = a % 1024; b = b % 1024; end
      r[i] = (a >= b) && (a < b + sz);
    end
    return r;
  endfunction

  task automatic step_check(input string tag);
    logic [3:0] em;
    logic [7:0] ei;
    em = exp_mem();
    ei = exp_io();
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (mem_hit !== em || io_hit !== ei || dev_sel !== ((em != 0) || (ei != 0))) begin
      errors++;
      $display("FAIL %s: mem_hit=%b io_hit=%b sel=%b expected mem_hit=%b io_hit=%b sel=%b",
               tag, mem_hit, io_hit, dev_sel, em, ei, (em != 0) || (ei != 0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    bus_addr = 24'h10_0000; mem_cyc = 1'b1; io_cyc = 1'b1;
    mem_base[15:0] = 16'h1000; mem_top[15:0] = 16'hFF00;
    repeat (3) @(negedge clk);
    vectors++;
    if (mem_hit !== 0 || io_hit !== 0 || dev_sel !== 0) begin
      errors++;
      $display("FAIL R1: mem_hit=%b io_hit=%b sel=%b expected all 0", mem_hit, io_hit, dev_sel);
    end
    rst_n = 1'b1;
    mem_cyc = 1'b0; io_cyc = 1'b0; mem_base = '0; mem_top = '0;
    step_check("R1");

    mem_cyc = 1'b1;
    mem_base[15:0] = 16'h1000; mem_top[15:0] = 16'hFF00;
    mem_base[31:16] = 16'h1000; mem_top[31:16] = 16'h1100;
    bus_addr = 24'h10_FFFF; step_check("R3");
    bus_addr = 24'h11_0000; step_check("R3");
    bus_addr = 24'h10_00A5; step_check("R3");
    bus_addr = 24'h10_0000; step_check("R4");
    bus_addr = 24'h0F_FFFF; step_check("R4");
    bus_addr = 24'h10_FFFF; step_check("R4");
    mem_top[15:0] = 16'h0000; mem_base[15:0] = 16'h0000;
    mem_base[31:16] = 16'h0000; mem_top[31:16] = 16'h0000;
    bus_addr = 24'h00_0000; step_check("R5");
    bus_addr = 24'h00_0012; step_check("R5");
    mem_base[15:0] = 16'h1000; mem_top[15:0] = 16'hFF00;
    bus_addr = 24'h10_4000; mem_cyc = 1'b0; io_cyc = 1'b1; step_check("R6");
    mem_cyc = 1'b1; step_check("R10");

    mem_cyc = 1'b0; mem_base = '0; mem_top = '0;
    io_base[15:0] = 16'h0220;
    bus_addr = 24'h00_0221; step_check("R7");
    bus_addr = 24'h00_0222; step_check("R7");
    bus_addr = 24'h00_021F; step_check("R7");
    io_base[15:0] = 16'h0000; bus_addr = 24'h00_0000; step_check("R8");
    bus_addr = 24'h00_0001; step_check("R8");
    io_base[15:0] = 16'h0220; bus_addr = 24'h00_FE21;
    io_dec10 = 1'b1; step_check("R9");
    io_dec10 = 1'b0; step_check("R9");
    io_cyc = 1'b0; bus_addr = 24'h00_0220; step_check("R6");

    for (int n = 0; n < 600; n++) begin
      int pick;
      for (int m = 0; m < 4; m++) begin
        mem_base[m*16 +: 16] = ($urandom % 5 == 0) ? 16'h0 : 16'($urandom);
        if (MODE[m]) mem_top[m*16 +: 16] = mem_base[m*16 +: 16] + 16'($urandom % 64);
        else mem_top[m*16 +: 16] = ($urandom % 5 == 0) ? 16'h0 : 16'($urandom) | 16'hF000;
      end
      for (int i = 0; i < 8; i++)
        io_base[i*16 +: 16] = ($urandom % 6 == 0) ? 16'h0 : 16'($urandom);
      mem_cyc = 1'($urandom); io_cyc = 1'($urandom); io_dec10 = 1'($urandom);
      pick = int'($urandom % 13);
      if (pick < 4)
        bus_addr = {mem_base[pick*16 +: 16] + 16'($urandom % 3), 8'($urandom)};
      else if (pick < 12)
        bus_addr = {8'($urandom), io_base[(pick-4)*16 +: 16] + 16'($urandom % 20) - 16'd2};
      else
        bus_addr = 24'($urandom);
      step_check("R2");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule